// File: doc/BRIEF.md
# Track Segment Neighbour Suppression Filter

This block sits behind a ring of track segment finders that cover one superlayer of a drift chamber trigger. In every clock cycle each segment presents an active flag, a two-bit code saying where inside the segment its priority wire lies, and a data word holding its timing values and wire hit pattern. A segment whose priority wire is the central one claims its place on the ring. An active segment whose priority wire is elsewhere, and which is directly next to a claiming segment, is dropped. The ring is closed: the first and last segments are neighbours.

Claim flags for all segments of one event are computed together and registered. The next stage then decides, for every segment at once, whether it survives, so the result never depends on the order in which segments are examined. Surviving segments pass their data word through unchanged; dropped and inactive segments present a zero flag and a zero data word. A new event may be presented on every clock cycle and its result appears two cycles later.

Top module: `tsns_ring_filter`

## Requirements
- R1: While the synchronous active-low reset is asserted, every output flag and every output data bit is zero, whatever the inputs.
- R2: A segment is a claimer when its active flag is 1 and its priority code equals 3; a claimer always appears at the output with its flag set and its data word unchanged.
- R3: An active segment whose priority code is 0, 1 or 2 is dropped (flag 0, data all zero) when the segment at index i-1 or at index i+1 is a claimer.
- R4: Neighbour indices wrap around the ring: segment 0 and segment N_SEG-1 are neighbours of each other for both claiming and dropping.
- R5: A segment whose active flag is 0 produces flag 0 and an all-zero data word, whatever its code and data.
- R6: An active non-claimer with no claimer on either side appears at the output with its flag set and its data word unchanged.
- R7: The result of an event appears exactly two clock cycles after it is presented, and events presented on consecutive cycles are filtered independently.
- R8: A segment whose code is 3 but whose active flag is 0 is not a claimer and does not drop its neighbours.
- R9: Each data word is SEG_W = 4*TIME_W + PAT_W bits: the hit pattern in bits [PAT_W-1:0], then the hit-pattern time, the found time, the fastest time and the priority time, each TIME_W bits, in ascending order; PAT_W is 15 when INNER_LAYER is 1 and 11 otherwise, and every bit of the word including the top pattern bit is carried through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_active_i | input | N_SEG | Active flag of each segment |
| seg_prio_i | input | 2*N_SEG | Priority code of segment i in bits [2i+1:2i] |
| seg_data_i | input | N_SEG*SEG_W | Data word of segment i in bits [i*SEG_W +: SEG_W] |
| out_active_o | output | N_SEG | Filtered flag of each segment |
| out_data_o | output | N_SEG*SEG_W | Data word of each surviving segment, zero otherwise |

## Verification
The bench aims at the ring seam: claimers at index 0 and at the last index with active non-claimers on the far side, which a design without wraparound would let through. It places inactive segments carrying code 3 next to active ones, which a design that ignored the active flag in the claim would wrongly drop, and adjacent claimers, which a design that let claimers drop each other would lose. Back-to-back events with opposite patterns expose any stage that mixes claim flags of one event with data of another, and a word with only its top pattern bit set shows whether the full 15-bit pattern is carried.

// File: rtl/tsns_pkg.sv
// Shared constants and helpers for the track segment neighbour suppression filter.
// Assumes a two-bit priority code where one value marks the central wire.
package tsns_pkg;
    localparam int          PRIO_W      = 2;
    localparam logic [1:0]  PRIO_CENTRE = 2'd3;

    // Hit pattern width: inner superlayer segments span more wires.
    function automatic int pat_width(input int inner);
        return (inner != 0) ? 15 : 11;
    endfunction

    // Ring neighbour at index idx-1 with wraparound.
    function automatic int ring_left(input int idx, input int n);
        return (idx == 0) ? n - 1 : idx - 1;
    endfunction

    // Ring neighbour at index idx+1 with wraparound.
    function automatic int ring_right(input int idx, input int n);
        return (idx == n - 1) ? 0 : idx + 1;
    endfunction
endpackage

// File: rtl/tsns_capture.sv
// Stage one: registers every segment's active flag and data word and computes
// its claim flag (active and central priority) for the whole ring in one pass.
// Assumes one event per clock cycle; synchronous active-low reset.
module tsns_capture
    import tsns_pkg::*;
#(
    parameter int N_SEG = 32,
    parameter int SEG_W = 51
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_SEG-1:0]         seg_active_i,
    input  logic [N_SEG*PRIO_W-1:0]  seg_prio_i,
    input  logic [N_SEG*SEG_W-1:0]   seg_data_i,
    output logic [N_SEG-1:0]         act_q,
    output logic [N_SEG-1:0]         claim_q,
    output logic [N_SEG*SEG_W-1:0]   data_q
);
    logic [N_SEG-1:0] claim_next;

    genvar gi;
    generate
        for (gi = 0; gi < N_SEG; gi++) begin : g_claim
            // Claim requires the segment to be active and centred (R2, R8).
            assign claim_next[gi] = seg_active_i[gi] &&
                                    (seg_prio_i[gi*PRIO_W +: PRIO_W] == PRIO_CENTRE);

            // R8: a registered claim always stems from an active centred segment.
            a_r8_claim_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
                claim_q[gi] |-> $past(seg_active_i[gi]) &&
                                ($past(seg_prio_i[gi*PRIO_W +: PRIO_W]) == PRIO_CENTRE));
        end
    endgenerate

    // Capture flags, claims and data of the current event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= '0;
            claim_q <= '0;
            data_q  <= '0;
        end else begin
            act_q   <= seg_active_i;
            claim_q <= claim_next;
            data_q  <= seg_data_i;
        end
    end
endmodule

// File: rtl/tsns_suppress.sv
// Stage two: using the registered claim flags of one event, keeps claimers,
// drops active non-claimers with a claiming neighbour on the ring, and zeroes
// every segment that does not survive. Assumes N_SEG >= 3.
module tsns_suppress
    import tsns_pkg::*;
#(
    parameter int N_SEG = 32,
    parameter int SEG_W = 51
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SEG-1:0]        act_i,
    input  logic [N_SEG-1:0]        claim_i,
    input  logic [N_SEG*SEG_W-1:0]  data_i,
    output logic [N_SEG-1:0]        out_active_o,
    output logic [N_SEG*SEG_W-1:0]  out_data_o
);
    logic [N_SEG-1:0]       nb_claim;
    logic [N_SEG-1:0]       keep;
    logic [N_SEG*SEG_W-1:0] gated;

    genvar gi;
    generate
        for (gi = 0; gi < N_SEG; gi++) begin : g_seg
            localparam int LEFT  = ring_left(gi, N_SEG);
            localparam int RIGHT = ring_right(gi, N_SEG);

            // Either ring neighbour claims its place (R3, R4).
            assign nb_claim[gi] = claim_i[LEFT] | claim_i[RIGHT];
            // Survive when active and either claiming or unopposed (R2, R6).
            assign keep[gi] = act_i[gi] & (claim_i[gi] | ~nb_claim[gi]);
            // Zero the word of any segment that does not survive (R3, R5).
            assign gated[gi*SEG_W +: SEG_W] = keep[gi] ? data_i[gi*SEG_W +: SEG_W] : '0;

            // R2: a claimer is never dropped and keeps its word.
            a_r2_claimer_kept: assert property (@(posedge clk) disable iff (!rst_n)
                claim_i[gi] |=> out_active_o[gi] &&
                    (out_data_o[gi*SEG_W +: SEG_W] == $past(data_i[gi*SEG_W +: SEG_W])));

            // R3/R4: active non-claimer next to a claimer (ring wrap) is dropped.
            a_r3_neighbour_drop: assert property (@(posedge clk) disable iff (!rst_n)
                (act_i[gi] && !claim_i[gi] && (claim_i[LEFT] || claim_i[RIGHT]))
                |=> !out_active_o[gi] && (out_data_o[gi*SEG_W +: SEG_W] == '0));

            // R5: an inactive segment is silent.
            a_r5_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
                !act_i[gi] |=> !out_active_o[gi] && (out_data_o[gi*SEG_W +: SEG_W] == '0));

            // R6: an active segment with no claiming neighbour passes.
            a_r6_lone_kept: assert property (@(posedge clk) disable iff (!rst_n)
                (act_i[gi] && !claim_i[LEFT] && !claim_i[RIGHT])
                |=> out_active_o[gi] &&
                    (out_data_o[gi*SEG_W +: SEG_W] == $past(data_i[gi*SEG_W +: SEG_W])));
        end
    endgenerate

    // Register the filtered flags and words for the whole ring.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_active_o <= '0;
            out_data_o   <= '0;
        end else begin
            out_active_o <= keep;
            out_data_o   <= gated;
        end
    end
endmodule

// File: rtl/tsns_ring_filter.sv
// Top: neighbour suppression over a closed ring of N_SEG track segments.
// Stage one registers claims, stage two filters; two cycles of latency,
// one event per cycle. Synchronous active-low reset.
module tsns_ring_filter
    import tsns_pkg::*;
#(
    parameter int N_SEG       = 32,
    parameter int TIME_W      = 9,
    parameter int INNER_LAYER = 1,
    localparam int PAT_W      = pat_width(INNER_LAYER),
    localparam int SEG_W      = 4 * TIME_W + PAT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_SEG-1:0]         seg_active_i,
    input  logic [N_SEG*PRIO_W-1:0]  seg_prio_i,
    input  logic [N_SEG*SEG_W-1:0]   seg_data_i,
    output logic [N_SEG-1:0]         out_active_o,
    output logic [N_SEG*SEG_W-1:0]   out_data_o
);
    logic [N_SEG-1:0]       act_q;
    logic [N_SEG-1:0]       claim_q;
    logic [N_SEG*SEG_W-1:0] data_q;

    tsns_capture #(.N_SEG(N_SEG), .SEG_W(SEG_W)) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .seg_active_i (seg_active_i),
        .seg_prio_i   (seg_prio_i),
        .seg_data_i   (seg_data_i),
        .act_q        (act_q),
        .claim_q      (claim_q),
        .data_q       (data_q)
    );

    tsns_suppress #(.N_SEG(N_SEG), .SEG_W(SEG_W)) u_suppress (
        .clk          (clk),
        .rst_n        (rst_n),
        .act_i        (act_q),
        .claim_i      (claim_q),
        .data_i       (data_q),
        .out_active_o (out_active_o),
        .out_data_o   (out_data_o)
    );

    // R1: one cycle into reset, the outputs are clear.
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(!rst_n) && !rst_n |-> (out_active_o == '0) && (out_data_o == '0));
endmodule

// File: tb/tb_tsns_ring_filter.sv
`timescale 1ns/1ps
module tb_tsns_ring_filter;
    localparam int N   = 32;
    localparam int TW  = 9;
    localparam int PW  = 15;
    localparam int SW  = 4 * TW + PW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   in_act;
    logic [2*N-1:0] in_pri;
    logic [N*SW-1:0] in_dat;
    logic [N-1:0]   o_act;
    logic [N*SW-1:0] o_dat;

    tsns_ring_filter #(.N_SEG(N), .TIME_W(TW), .INNER_LAYER(1)) dut (
        .clk(clk), .rst_n(rst_n),
        .seg_active_i(in_act), .seg_prio_i(in_pri), .seg_data_i(in_dat),
        .out_active_o(o_act), .out_data_o(o_dat)
    );

    always #5 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    // Stimulus under construction and two pipeline slots of pending events.
    logic [N-1:0]    s_act;
    logic [2*N-1:0]  s_pri;
    logic [N*SW-1:0] s_dat;
    logic [N-1:0]    p0_act, p1_act;
    logic [2*N-1:0]  p0_pri, p1_pri;
    logic [N*SW-1:0] p0_dat, p1_dat;
    bit              pv0, pv1;
    string           t0, t1;

    function automatic bit claims(input logic [N-1:0] a, input logic [2*N-1:0] p, input int i);
        return a[i] && (p[2*i +: 2] == 2'd3);
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    // Compare outputs with the model for one stored event.
    task automatic compare(input logic [N-1:0] a, input logic [2*N-1:0] p,
                           input logic [N*SW-1:0] d, input string tag);
        for (int i = 0; i < N; i++) begin
            int l = (i == 0) ? N - 1 : i - 1;
            int r = (i == N - 1) ? 0 : i + 1;
            bit nb = claims(a, p, l) || claims(a, p, r);
            bit keep = a[i] && (claims(a, p, i) || !nb);
            logic [SW-1:0] ed = keep ? d[i*SW +: SW] : '0;
            string tg;
            if (tag != "")                tg = tag;
            else if (!a[i])               tg = "R5";
            else if (claims(a, p, i))     tg = "R2";
            else if (nb)                  tg = (i == 0 || i == N - 1) ? "R4" : "R3";
            else if ((p[2*l +: 2] == 2'd3) || (p[2*r +: 2] == 2'd3)) tg = "R8";
            else                          tg = "R6";
            n_chk++;
            if (o_act[i] !== keep || o_dat[i*SW +: SW] !== ed) begin
                n_fail++;
                $display("FAIL %s seg %0d: act=%b data=%h expected act=%b data=%h",
                         tg, i, o_act[i], o_dat[i*SW +: SW], keep, ed);
            end
        end
    endtask

    // One event per negedge: check the event from two cycles back, then drive.
    task automatic step(input string tag);
        @(negedge clk);
        if (pv1) compare(p1_act, p1_pri, p1_dat, t1);
        p1_act = p0_act; p1_pri = p0_pri; p1_dat = p0_dat; pv1 = pv0; t1 = t0;
        p0_act = s_act;  p0_pri = s_pri;  p0_dat = s_dat;  pv0 = 1;   t0 = tag;
        in_act = s_act; in_pri = s_pri; in_dat = s_dat;
    endtask

    task automatic clear_stim();
        s_act = '0; s_pri = '0; s_dat = '0;
    endtask

    task automatic randomize_stim();
        for (int i = 0; i < N; i++) begin
            logic [63:0] w = {$urandom(), $urandom()};
            s_act[i] = ($urandom() % 4) != 0;
            s_pri[2*i +: 2] = 2'($urandom() % 4);
            s_dat[i*SW +: SW] = w[SW-1:0];
        end
    endtask

    task automatic set_seg(input int i, input bit a, input logic [1:0] p);
        logic [63:0] w = {$urandom(), $urandom()};
        s_act[i] = a;
        s_pri[2*i +: 2] = p;
        s_dat[i*SW +: SW] = w[SW-1:0] | 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        pv0 = 0; pv1 = 0; t0 = ""; t1 = "";
        p0_act = '0; p0_pri = '0; p0_dat = '0;
        p1_act = '0; p1_pri = '0; p1_dat = '0;
        // R1: busy inputs during reset must not reach the outputs.
        randomize_stim();
        s_act = '1; s_pri = '0;
        in_act = s_act; in_pri = s_pri; in_dat = s_dat;
        repeat (3) begin
            @(negedge clk);
            n_chk++;
            if (o_act !== '0 || o_dat !== '0) begin
                n_fail++;
                $display("FAIL R1 reset: act=%h expected 0", o_act);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;
        clear_stim();
        in_act = '0; in_pri = '0; in_dat = '0;

        // R4: claimer at 0, active non-claimers on both sides including the seam.
        clear_stim();
        set_seg(0, 1, 2'd3); set_seg(N-1, 1, 2'd0); set_seg(1, 1, 2'd2);
        set_seg(10, 1, 2'd1);
        step("");
        // R4: claimer at the last index drops segment 0.
        clear_stim();
        set_seg(N-1, 1, 2'd3); set_seg(0, 1, 2'd1); set_seg(N-2, 1, 2'd0);
        step("");
        // R2: adjacent claimers both survive; R3 non-claimer between claimers dropped.
        clear_stim();
        set_seg(5, 1, 2'd3); set_seg(6, 1, 2'd3); set_seg(7, 1, 2'd0);
        set_seg(12, 1, 2'd3); set_seg(13, 1, 2'd1); set_seg(14, 1, 2'd3);
        step("");
        // R8: inactive code-3 segments do not drop active neighbours.
        clear_stim();
        set_seg(20, 0, 2'd3); set_seg(19, 1, 2'd1); set_seg(21, 1, 2'd2);
        set_seg(0, 0, 2'd3); set_seg(N-1, 1, 2'd0); set_seg(1, 1, 2'd0);
        step("");
        // R5: all inactive with random codes and data.
        randomize_stim(); s_act = '0;
        step("");
        // R9: only the top pattern bit set on a lone segment.
        clear_stim();
        s_act[8] = 1'b1; s_pri[16 +: 2] = 2'd0; s_dat[8*SW + PW - 1] = 1'b1;
        step("R9");
        // R7: back-to-back opposite events keep their own results.
        clear_stim();
        for (int i = 0; i < N; i += 2) set_seg(i, 1, 2'd3);
        for (int i = 1; i < N; i += 2) set_seg(i, 1, 2'd0);
        step("R7");
        for (int i = 0; i < N; i++) set_seg(i, 1, (i % 2 == 1) ? 2'd3 : 2'd1);
        step("R7");
        clear_stim();
        for (int i = 0; i < N; i++) set_seg(i, 1, 2'd0);
        step("R7");
        // Random events, one per cycle.
        for (int k = 0; k < 400; k++) begin
            randomize_stim();
            step("");
        end
        clear_stim();
        step(""); step(""); step("");
        summary();
    end
endmodule